// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block collects four maskable interrupt sources for a small 8-bit processor core and presents one request strobe and one 12-bit vector address to it. Two sources are level requests from timers. Each timer's request flag counts only while that timer's mask bit is 1. The other two sources come from pins: a vertical-sync input and a power-fail input. Both pins pass through a two-flop synchronizer. An edge detector with selectable polarity then sets a stored flag.

The vertical-sync flag is used inside the block as an inverted copy of the pin. It is cleared only when the core acknowledges line 2. The power-input latch is cleared only by a software strobe. While the latch is set and the source is enabled, the power line is held active.

A global enable gates delivery to the core but never clears stored edges. Edges that arrive while delivery is off are still stored, and they are delivered once delivery is turned back on. An edge that arrives while its own source is disabled is dropped. When several lines are pending, the lowest line number wins.

Top module: `irq_mixed_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0x000, every option bit is 0 and no flag is stored.
- R2: Line 1 is pending while `t2_flag` and `t2_mask` are both 1 and option bit 6 is 1. It is a level source with vector 0xFF6. If any of the three conditions is 0, line 1 does not request.
- R3: Line 3 is pending while `t1_flag` and `t1_mask` are both 1. It is a level source with vector 0xFF2, and it stops requesting as soon as the flag drops.
- R4: Line 2 uses vector 0xFF4 and is enabled by option bit 3. The internal signal is the inverse of `vsync_pin`. Option bit 5 = 0 stores an edge when the internal signal falls (a pin rising edge). Option bit 5 = 1 stores an edge when the internal signal rises (a pin falling edge).
- R5: A stored line-2 flag stays set until `ack_valid` is 1 with `ack_line` = 2. An acknowledge that carries any other line number leaves the flag set.
- R6: If a line-2 acknowledge and a new active line-2 edge fall in the same cycle, the flag stays set.
- R7: Line 4 uses vector 0xFF0 and is enabled by option bit 2. Option bit 4 = 1 sets the power latch on a `pwr_pin` rising edge; bit 4 = 0 sets it on a falling edge. The latch then holds through any further pin activity until `pwr_clr` is pulsed.
- R8: While option bit 7 (global enable) is 0, `irq_req` is 0 and `irq_vec` is 0x000. Edges that arrive in that time are still stored, and they request once bit 7 is set.
- R9: An edge on `vsync_pin` or `pwr_pin` that arrives while its source enable (bit 3 or bit 2) is 0 is not stored, and it does not request after the source is enabled.
- R10: When several lines are pending, the vector is that of the lowest line number: line 1, then 2, then 3, then 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Write strobe for the option register |
| opt_wdata | input | 6 (bits 7:2) | Option data: 7 global enable, 6 line-1 enable, 5 vsync edge select, 4 power edge select, 3 vsync enable, 2 power enable |
| pwr_clr | input | 1 | Software reset of the power latch |
| t1_flag | input | 1 | Timer-1 request flag |
| t1_mask | input | 1 | Timer-1 interrupt mask (1 = pass) |
| t2_flag | input | 1 | Timer-2 request flag |
| t2_mask | input | 1 | Timer-2 interrupt mask (1 = pass) |
| vsync_pin | input | 1 | Asynchronous vertical-sync pin |
| pwr_pin | input | 1 | Asynchronous power-fail pin |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_line | input | 3 | Number of the line being serviced (1 to 4) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 12 | Vector of the selected line; 0x000 when there is no request |

## Verification
The level lines are driven with each combination of flag, mask and enable, so a missing gate term is exposed. The vertical-sync pin is toggled in both directions under both polarity settings, which separates the inversion from the edge selection. Acknowledges are sent with the wrong line number, with the right one, and in the exact cycle a new edge lands, so the clear-versus-set order is tested. Edges are also sent while global delivery is off and while a source is disabled. Together with a stack of all four pending lines peeled off one at a time, these runs separate the "stored but held back" case from "never stored" and confirm the priority order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLINES   = 4;
  localparam int VEC_W    = 12;
  localparam logic [VEC_W-1:0] VEC_TOP = 12'hFF6;
  localparam int VEC_STEP = 2;

  // option register bit positions (software decodes these)
  localparam int OPT_GEN   = 7;
  localparam int OPT_T2EN  = 6;
  localparam int OPT_VSPOL = 5;
  localparam int OPT_PWPOL = 4;
  localparam int OPT_VSEN  = 3;
  localparam int OPT_PWEN  = 2;

  // vector of a line given its zero-based index (line number minus one)
  function automatic logic [VEC_W-1:0] line_vector(input int unsigned idx);
    return VEC_TOP - VEC_W'(VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_sel,
  input  logic en,
  output logic hit
);
  logic prev_q;
  logic rise_ev;
  logic fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise_ev = level & ~prev_q;
  assign fall_ev = ~level & prev_q;
  assign hit     = en & (rise_sel ? rise_ev : fall_ev);

  AST_HIT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en); // R9
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/irq_mixed_ctrl.sv
module irq_mixed_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opt_we,
  input  logic [7:2]  opt_wdata,
  input  logic        pwr_clr,
  input  logic        t1_flag,
  input  logic        t1_mask,
  input  logic        t2_flag,
  input  logic        t2_mask,
  input  logic        vsync_pin,
  input  logic        pwr_pin,
  input  logic        ack_valid,
  input  logic [2:0]  ack_line,
  output logic        irq_req,
  output logic [11:0] irq_vec
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [7:2]        opt_q;
  logic [1:0]        pin_s;
  logic              vs_int;
  logic              vs_hit;
  logic              pw_hit;
  logic              ack_vs;
  logic              vs_flag;
  logic              pw_latch;
  logic              t1_req_n;
  logic              t2_req_n;
  logic              pwr_int_n;
  logic [NLINES-1:0] pend;
  logic              pend_any;
  logic [IW-1:0]     win_idx;

  // option register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opt_q <= '0;
    else if (opt_we) opt_q <= opt_wdata;
  end

  // pin synchronizers: bit 0 vsync, bit 1 power
  irq_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pwr_pin, vsync_pin}),
    .q     (pin_s)
  );

  // vsync: inverted copy of the pin, forced low when disabled
  assign vs_int = opt_q[OPT_VSEN] ? ~pin_s[0] : 1'b0;

  irq_edge_det u_vs_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (vs_int),
    .rise_sel (opt_q[OPT_VSPOL]),
    .en       (opt_q[OPT_VSEN]),
    .hit      (vs_hit)
  );

  irq_edge_det u_pw_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (pin_s[1]),
    .rise_sel (opt_q[OPT_PWPOL]),
    .en       (opt_q[OPT_PWEN]),
    .hit      (pw_hit)
  );

  assign ack_vs = ack_valid && (ack_line == 3'd2);

  // line-2 edge flag: a new edge wins over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vs_flag <= 1'b0;
    else if (vs_hit) vs_flag <= 1'b1;
    else if (ack_vs) vs_flag <= 1'b0;
  end

  // power latch: software clear, a new edge wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pw_latch <= 1'b0;
    else if (pw_hit)  pw_latch <= 1'b1;
    else if (pwr_clr) pw_latch <= 1'b0;
  end

  // low-active request levels as seen at each line
  assign t2_req_n  = ~(t2_flag & t2_mask);
  assign t1_req_n  = ~(t1_flag & t1_mask);
  assign pwr_int_n = ~(pw_latch & opt_q[OPT_PWEN]);

  assign pend[0] = ~t2_req_n & opt_q[OPT_T2EN];
  assign pend[1] = vs_flag;
  assign pend[2] = ~t1_req_n;
  assign pend[3] = ~pwr_int_n;

  irq_prio #(.N(NLINES)) u_prio (
    .pend (pend),
    .any  (pend_any),
    .idx  (win_idx)
  );

  assign irq_req = opt_q[OPT_GEN] & pend_any;
  assign irq_vec = irq_req ? line_vector(32'(win_idx)) : '0;

  AST_VS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    vs_flag && !ack_vs |=> vs_flag); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vs_flag && ack_vs && !vs_hit |=> !vs_flag); // R5
  AST_ACK_RACE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vs && vs_hit |=> vs_flag); // R6
  AST_PW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pw_latch && !pwr_clr |=> pw_latch); // R7
  AST_MASKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    vs_flag && !opt_q[OPT_GEN] && !ack_valid |=> vs_flag); // R8
  AST_VS_OFF_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_flag && !opt_q[OPT_VSEN] |=> !vs_flag); // R9
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && pend[0] |-> irq_vec == 12'hFF6); // R10
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[0] == 1'b0) && (irq_vec >= 12'hFF0) && (irq_vec <= 12'hFF6)); // R10
endmodule

// File: tb/tb_irq_mixed_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mixed_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_we = 1'b0;
  logic [7:2]  opt_wdata = '0;
  logic        pwr_clr = 1'b0;
  logic        t1_flag = 1'b0, t1_mask = 1'b0;
  logic        t2_flag = 1'b0, t2_mask = 1'b0;
  logic        vsync_pin = 1'b1, pwr_pin = 1'b1;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_line = 3'd0;
  logic        irq_req;
  logic [11:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mixed_ctrl dut (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
    .pwr_clr(pwr_clr), .t1_flag(t1_flag), .t1_mask(t1_mask),
    .t2_flag(t2_flag), .t2_mask(t2_mask), .vsync_pin(vsync_pin),
    .pwr_pin(pwr_pin), .ack_valid(ack_valid), .ack_line(ack_line),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // bench-side option encoding
  localparam logic [7:0] GEN = 8'h80, T2EN = 8'h40, VSPOL = 8'h20,
                         PWPOL = 8'h10, VSEN = 8'h08, PWEN = 8'h04;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_req, input logic [11:0] exp_vec);
    total++;
    if (irq_req !== exp_req || irq_vec !== exp_vec) begin
      bad++;
      $display("FAIL %s: got req=%0b vec=%03h, expected req=%0b vec=%03h",
               req, irq_req, irq_vec, exp_req, exp_vec);
    end
  endtask

  task automatic wr_opt(input logic [7:0] v);
    @(negedge clk);
    opt_we = 1'b1; opt_wdata = v[7:2];
    @(negedge clk);
    opt_we = 1'b0;
  endtask

  task automatic ack(input logic [2:0] line);
    @(negedge clk);
    ack_valid = 1'b1; ack_line = line;
    @(negedge clk);
    ack_valid = 1'b0; ack_line = 3'd0;
  endtask

  task automatic clr_pwr();
    @(negedge clk); pwr_clr = 1'b1;
    @(negedge clk); pwr_clr = 1'b0;
  endtask

  task automatic cleanup();
    wr_opt(8'h00);
    t1_flag = 0; t1_mask = 0; t2_flag = 0; t2_mask = 0;
    vsync_pin = 1'b1; pwr_pin = 1'b1;
    tick(5);
    clr_pwr();
    ack(3'd2);
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", 1'b0, 12'h000);
    wr_opt(GEN);
    chk("R1 no stored flag after reset", 1'b0, 12'h000);
    cleanup();
  endtask

  task automatic t_levels();
    wr_opt(GEN | T2EN);
    t2_flag = 1; t2_mask = 1; tick(1);
    chk("R2 timer2 pending", 1'b1, 12'hFF6);
    t2_mask = 0; tick(1);
    chk("R2 timer2 masked", 1'b0, 12'h000);
    t2_mask = 1; wr_opt(GEN); tick(1);
    chk("R2 option bit6 off", 1'b0, 12'h000);
    t2_flag = 0; t2_mask = 0;
    t1_flag = 1; t1_mask = 1; tick(1);
    chk("R3 timer1 pending", 1'b1, 12'hFF2);
    t1_mask = 0; tick(1);
    chk("R3 timer1 masked", 1'b0, 12'h000);
    t1_mask = 1; t1_flag = 0; tick(1);
    chk("R3 timer1 level drops", 1'b0, 12'h000);
    cleanup();
  endtask

  task automatic t_vsync();
    wr_opt(GEN | VSEN);             // internal falling = pin rising
    vsync_pin = 0; tick(5);
    chk("R4 pin falling ignored with bit5=0", 1'b0, 12'h000);
    vsync_pin = 1; tick(5);
    chk("R4 pin rising stored with bit5=0", 1'b1, 12'hFF4);
    ack(3'd3); tick(1);
    chk("R5 wrong-line ack keeps flag", 1'b1, 12'hFF4);
    ack(3'd2); tick(1);
    chk("R5 line-2 ack clears flag", 1'b0, 12'h000);
    wr_opt(GEN | VSEN | VSPOL);     // internal rising = pin falling
    vsync_pin = 0; tick(5);
    chk("R4 pin falling stored with bit5=1", 1'b1, 12'hFF4);
    ack(3'd2); vsync_pin = 1; tick(5);
    chk("R4 pin rising ignored with bit5=1", 1'b0, 12'h000);
    // set flag, then race a new edge against the acknowledge
    vsync_pin = 0; tick(5);
    vsync_pin = 1; tick(5);
    vsync_pin = 0;                  // driven at a falling clock edge
    @(negedge clk);                 // first sync stage loaded
    @(negedge clk);                 // edge visible this cycle
    ack_valid = 1; ack_line = 3'd2;
    @(negedge clk);
    ack_valid = 0; ack_line = 3'd0;
    tick(1);
    chk("R6 edge wins over same-cycle ack", 1'b1, 12'hFF4);
    ack(3'd2); tick(1);
    chk("R5 later ack clears", 1'b0, 12'h000);
    cleanup();
  endtask

  task automatic t_gen();
    wr_opt(VSEN | VSPOL);
    vsync_pin = 0; tick(5);
    chk("R8 no request while global off", 1'b0, 12'h000);
    wr_opt(GEN | VSEN | VSPOL); tick(1);
    chk("R8 stored edge delivered after enable", 1'b1, 12'hFF4);
    wr_opt(VSEN | VSPOL); tick(1);
    chk("R8 global off hides pending", 1'b0, 12'h000);
    wr_opt(GEN | VSEN | VSPOL); tick(1);
    chk("R8 flag survived global off", 1'b1, 12'hFF4);
    cleanup();
  endtask

  task automatic t_disabled();
    wr_opt(GEN | VSPOL);
    vsync_pin = 0; tick(5);
    vsync_pin = 1; tick(5);
    wr_opt(GEN | VSEN | VSPOL); tick(3);
    chk("R9 vsync edge while disabled dropped", 1'b0, 12'h000);
    wr_opt(GEN | PWPOL);
    pwr_pin = 0; tick(5);
    pwr_pin = 1; tick(5);
    wr_opt(GEN | PWEN | PWPOL); tick(3);
    chk("R9 power edge while disabled dropped", 1'b0, 12'h000);
    cleanup();
  endtask

  task automatic t_power();
    wr_opt(GEN | PWEN | PWPOL);
    pwr_pin = 0; tick(5);
    chk("R7 falling ignored in rising mode", 1'b0, 12'h000);
    pwr_pin = 1; tick(5);
    chk("R7 rising sets latch", 1'b1, 12'hFF0);
    pwr_pin = 0; tick(5);
    chk("R7 latch holds after pin drops", 1'b1, 12'hFF0);
    ack(3'd4); tick(1);
    chk("R7 ack does not clear latch", 1'b1, 12'hFF0);
    clr_pwr(); tick(1);
    chk("R7 software clear", 1'b0, 12'h000);
    pwr_pin = 1; tick(5);
    wr_opt(GEN | PWEN);
    pwr_pin = 0; tick(5);
    chk("R7 falling sets latch in falling mode", 1'b1, 12'hFF0);
    cleanup();
  endtask

  task automatic t_prio();
    wr_opt(GEN | T2EN | VSPOL | PWPOL | VSEN | PWEN);
    vsync_pin = 0; pwr_pin = 0; tick(5);
    pwr_pin = 1; tick(5);
    t1_flag = 1; t1_mask = 1; t2_flag = 1; t2_mask = 1; tick(1);
    chk("R10 line1 first", 1'b1, 12'hFF6);
    t2_flag = 0; tick(1);
    chk("R10 line2 next", 1'b1, 12'hFF4);
    ack(3'd2); tick(1);
    chk("R10 line3 next", 1'b1, 12'hFF2);
    t1_flag = 0; tick(1);
    chk("R10 line4 last", 1'b1, 12'hFF0);
    clr_pwr(); tick(1);
    chk("R10 nothing left", 1'b0, 12'h000);
    cleanup();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_levels();
    t_vsync();
    t_gen();
    t_disabled();
    t_power();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, got hung, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule